// File: doc/BRIEF.md
# SDRAM Bank Command Timing Guard

This block follows a single SDRAM bank and works out, cycle by cycle, which commands the bank can take next. It sees every command the controller actually issues (activate, read, write, precharge). From these and from four timing values held in its own configuration registers, it raises one permit flag per command type. It also keeps track of whether the bank holds an open row, flags reads or writes that reach a closed bank, and marks the cycles in which read data should be on the bus.

Every interval is a whole number of memory clock cycles, and every event is taken on the rising clock edge. Write data follows the write command after a fixed write latency and runs for a fixed burst length. The write-recovery and write-to-read windows start from the last beat of that data, not from the write command. A single-beat read runs as a full burst, so the read-data window always covers a whole burst. Boot code loads the configuration before any access. A write to the configuration takes effect only while configuration is enabled and the bank is closed.

Top module: `ddr_bank_guard`

## Requirements
- R1: Four interval registers, picked by `cfg_sel`: 0 = activate to read/write, 1 = write recovery, 2 = write to read, 3 = CAS latency. Reset loads the parameter defaults of 3, 3, 2 and 2. A value written at an edge is used from the next cycle on.
- R2: After an ACTIVATE issued in cycle T with activate-to-read/write value N, `rd_ok` and `wr_ok` are low until cycle T+N and high from then on. A value of 0 or 1 makes them high in cycle T+1.
- R3: Write data occupies cycles W+1 to W+4 after a WRITE in cycle W. `pre_ok` stays low through the burst and until L+N, where L = W+4 is the last beat and N is the write-recovery value.
- R4: `rd_ok` stays low through a write burst and until L+M, where M is the write-to-read value. It is high from that cycle on.
- R5: After a READ in cycle R with CAS latency C, `rd_data_due` is high in cycles R+C to R+C+3 and low in R+1 to R+C-1. A latency of 0 is taken as 1.
- R6: A READ (`cmd_code` 1) or WRITE (`cmd_code` 2) issued while the bank is closed raises `illegal_cmd` for exactly the next cycle. It starts no read-data window and no write burst.
- R7: A WRITE issued before the previous write's windows have ended restarts the recovery and write-to-read windows from the new burst's last beat.
- R8: A configuration write takes effect only when `cfg_en` and `cfg_we` are both high and the bank is closed. At any other time it is ignored.
- R9: ACTIVATE (`cmd_code` 0) opens the bank and PRECHARGE (`cmd_code` 3) closes it, both from the next cycle. `act_ok` is high exactly while the bank is closed. `rd_ok`, `wr_ok` and `pre_ok` are low while it is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Configuration enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Interval register select |
| cfg_data | input | CNT_W | Interval value in cycles |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_code | input | 2 | Command: 0 activate, 1 read, 2 write, 3 precharge |
| act_ok | output | 1 | ACTIVATE permitted this cycle |
| rd_ok | output | 1 | READ permitted this cycle |
| wr_ok | output | 1 | WRITE permitted this cycle |
| pre_ok | output | 1 | PRECHARGE permitted this cycle |
| bank_open | output | 1 | Bank holds an open row |
| rd_data_due | output | 1 | Read data expected on the bus this cycle |
| illegal_cmd | output | 1 | Read or write reached a closed bank in the previous cycle |

## Verification
Some properties are checked on every cycle. Activate and precharge move the open-row state one cycle later. A read or write to a closed bank always raises the error flag in the following cycle, and that flag never appears without such a cause. A write to an open bank blocks both precharge and read in the next cycle. The interval registers do not change while configuration is disabled or a row is open. The exact cycle in which each window ends depends on the value programmed. Showing that needs directed scenarios: activate-to-access timing, read-data placement for CAS latencies of 0, 2 and 3, recovery and write-to-read timing counted from the last beat, a recovery window restarted by a second write, and configuration writes that must be ignored.

// File: rtl/ddr_bank_guard_pkg.sv
package ddr_bank_guard_pkg;

   typedef enum logic [1:0] {
      CMD_ACT = 2'd0,
      CMD_RD  = 2'd1,
      CMD_WR  = 2'd2,
      CMD_PRE = 2'd3
   } bank_cmd_e;

   // interval register indices
   localparam int CFG_ACT_RW = 0;
   localparam int CFG_WR_REC = 1;
   localparam int CFG_WR_RD  = 2;
   localparam int CFG_CAS    = 3;
   localparam int CFG_NUM    = 4;
   localparam int CFG_SEL_W  = $clog2(CFG_NUM);

   // down-counter indices
   localparam int CT_ACT   = 0;
   localparam int CT_BURST = 1;
   localparam int CT_REC   = 2;
   localparam int CT_WTR   = 3;
   localparam int CT_RD    = 4;
   localparam int CT_NUM   = 5;

endpackage

// File: rtl/ddr_guard_cfg.sv
module ddr_guard_cfg
   import ddr_bank_guard_pkg::*;
#(
   parameter int W      = 4,
   parameter int DEF_0  = 3,
   parameter int DEF_1  = 3,
   parameter int DEF_2  = 2,
   parameter int DEF_3  = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [CFG_SEL_W-1:0]           wr_sel,
   input  logic [W-1:0]                   wr_data,
   output logic [CFG_NUM-1:0][W-1:0]      val
);

   localparam logic [CFG_NUM-1:0][W-1:0] RST_VAL =
      {W'(DEF_3), W'(DEF_2), W'(DEF_1), W'(DEF_0)};

   for (genvar i = 0; i < CFG_NUM; i++) begin : g_reg
      localparam logic [CFG_SEL_W-1:0] SEL = CFG_SEL_W'(i);
      always_ff @(posedge clk) begin
         if (!rst_n)
            val[i] <= RST_VAL[i];
         else if (wr_en && wr_sel == SEL)
            val[i] <= wr_data;
      end
   end

endmodule

// File: rtl/ddr_guard_cnt.sv
module ddr_guard_cnt #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
   import ddr_bank_guard_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter int BURST_LEN  = 4,
   parameter int WR_LAT     = 1,
   parameter int DEF_ACT_RW = 3,
   parameter int DEF_WR_REC = 3,
   parameter int DEF_WR_RD  = 2,
   parameter int DEF_CAS    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_en,
   input  logic                 cfg_we,
   input  logic [1:0]           cfg_sel,
   input  logic [CNT_W-1:0]     cfg_data,
   input  logic                 cmd_valid,
   input  logic [1:0]           cmd_code,
   output logic                 act_ok,
   output logic                 rd_ok,
   output logic                 wr_ok,
   output logic                 pre_ok,
   output logic                 bank_open,
   output logic                 rd_data_due,
   output logic                 illegal_cmd
);

   localparam int CW = CNT_W + $clog2(BURST_LEN + WR_LAT) + 1;
   localparam logic [CW-1:0] BURST_LOAD = CW'(WR_LAT + BURST_LEN - 1);
   localparam logic [CW-1:0] RD_TAIL    = CW'(BURST_LEN - 1);
   localparam logic [CW-1:0] RD_SPAN    = CW'(BURST_LEN);

   if (BURST_LEN < 2 || WR_LAT < 1 || CNT_W < 2) begin : g_bad_shape
      $error("ddr_bank_guard: BURST_LEN>=2, WR_LAT>=1, CNT_W>=2 required");
   end
   if (DEF_ACT_RW >= (1 << CNT_W) || DEF_WR_REC >= (1 << CNT_W) ||
       DEF_WR_RD >= (1 << CNT_W) || DEF_CAS >= (1 << CNT_W)) begin : g_bad_def
      $error("ddr_bank_guard: default interval does not fit CNT_W");
   end

   bank_cmd_e cmd;
   logic      is_act, is_rd, is_wr, is_pre;
   logic      open_q, bad_q;

   assign cmd    = bank_cmd_e'(cmd_code);
   assign is_act = cmd_valid && (cmd == CMD_ACT);
   assign is_rd  = cmd_valid && (cmd == CMD_RD);
   assign is_wr  = cmd_valid && (cmd == CMD_WR);
   assign is_pre = cmd_valid && (cmd == CMD_PRE);

   // ---------------- interval registers ----------------
   logic [CFG_NUM-1:0][CNT_W-1:0] cfg_val;
   logic [CNT_W-1:0] t_act_rw, t_wr_rec, t_wr_rd, t_cas;

   ddr_guard_cfg #(
      .W(CNT_W), .DEF_0(DEF_ACT_RW), .DEF_1(DEF_WR_REC),
      .DEF_2(DEF_WR_RD), .DEF_3(DEF_CAS)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_en && cfg_we && !open_q),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_data),
      .val     (cfg_val)
   );

   assign t_act_rw = cfg_val[CFG_ACT_RW];
   assign t_wr_rec = cfg_val[CFG_WR_REC];
   assign t_wr_rd  = cfg_val[CFG_WR_RD];
   assign t_cas    = cfg_val[CFG_CAS];

   // interval N counted from cycle T expires in cycle T+N (N=0 acts as 1)
   function automatic logic [CW-1:0] gap_load(input logic [CNT_W-1:0] v);
      return (v == '0) ? '0 : (CW'(v) - CW'(1));
   endfunction

   // ---------------- counters ----------------
   logic [CT_NUM-1:0]         ct_ld;
   logic [CT_NUM-1:0][CW-1:0] ct_val;
   logic [CT_NUM-1:0][CW-1:0] ct_cnt;
   logic                      last_beat;
   logic [CW-1:0]             cas_eff;

   assign last_beat = (ct_cnt[CT_BURST] == CW'(1));
   assign cas_eff   = (t_cas == '0) ? CW'(1) : CW'(t_cas);

   always_comb begin
      ct_ld[CT_ACT]    = is_act;
      ct_val[CT_ACT]   = gap_load(t_act_rw);
      ct_ld[CT_BURST]  = is_wr && open_q;
      ct_val[CT_BURST] = BURST_LOAD;
      ct_ld[CT_REC]    = last_beat;
      ct_val[CT_REC]   = gap_load(t_wr_rec);
      ct_ld[CT_WTR]    = last_beat;
      ct_val[CT_WTR]   = gap_load(t_wr_rd);
      ct_ld[CT_RD]     = is_rd && open_q;
      ct_val[CT_RD]    = cas_eff + RD_TAIL;
   end

   for (genvar k = 0; k < CT_NUM; k++) begin : g_cnt
      ddr_guard_cnt #(.W(CW)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (ct_ld[k]),
         .load_val (ct_val[k]),
         .cnt      (ct_cnt[k])
      );
   end

   // ---------------- bank state ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         bad_q  <= 1'b0;
      end else begin
         if (is_act)
            open_q <= 1'b1;
         else if (is_pre)
            open_q <= 1'b0;
         bad_q <= (is_rd || is_wr) && !open_q;
      end
   end

   // ---------------- permits ----------------
   assign bank_open   = open_q;
   assign illegal_cmd = bad_q;
   assign act_ok      = !open_q;
   assign wr_ok       = open_q && (ct_cnt[CT_ACT] == '0);
   assign rd_ok       = open_q && (ct_cnt[CT_ACT] == '0) &&
                        (ct_cnt[CT_BURST] == '0) && (ct_cnt[CT_WTR] == '0);
   assign pre_ok      = open_q && (ct_cnt[CT_BURST] == '0) &&
                        (ct_cnt[CT_REC] == '0);
   assign rd_data_due = (ct_cnt[CT_RD] != '0) && (ct_cnt[CT_RD] <= RD_SPAN);

endmodule

// File: rtl/ddr_bank_guard_chk.sv
module ddr_bank_guard_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_en,
   input logic             cmd_valid,
   input logic [1:0]       cmd_code,
   input logic             rd_ok,
   input logic             pre_ok,
   input logic             bank_open,
   input logic             illegal_cmd,
   input logic [CNT_W-1:0] t_act_rw,
   input logic [CNT_W-1:0] t_wr_rec,
   input logic [CNT_W-1:0] t_wr_rd,
   input logic [CNT_W-1:0] t_cas
);

   logic rw_cmd, wr_cmd;
   assign rw_cmd = cmd_valid && (cmd_code == 2'd1 || cmd_code == 2'd2);
   assign wr_cmd = cmd_valid && (cmd_code == 2'd2);

   p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en || bank_open) |=> $stable({t_act_rw, t_wr_rec, t_wr_rd, t_cas}));

   p_act_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 2'd0) |=> bank_open);

   p_pre_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 2'd3) |=> !bank_open);

   p_closed_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rw_cmd && !bank_open) |=> illegal_cmd);

   p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_cmd |-> $past(rw_cmd && !bank_open));

   p_wr_blocks_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && bank_open) |=> !pre_ok);

   p_wr_blocks_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && bank_open) |=> !rd_ok);

endmodule

bind ddr_bank_guard ddr_bank_guard_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_en      (cfg_en),
   .cmd_valid   (cmd_valid),
   .cmd_code    (cmd_code),
   .rd_ok       (rd_ok),
   .pre_ok      (pre_ok),
   .bank_open   (bank_open),
   .illegal_cmd (illegal_cmd),
   .t_act_rw    (t_act_rw),
   .t_wr_rec    (t_wr_rec),
   .t_wr_rd     (t_wr_rd),
   .t_cas       (t_cas)
);

// File: tb/ddr_bank_guard_bench.sv
`timescale 1ns/1ps
module ddr_bank_guard_bench;

   localparam logic [1:0] C_ACT = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_PRE = 2'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_en = 1'b0, cfg_we = 1'b0;
   logic [1:0] cfg_sel = 2'd0;
   logic [3:0] cfg_data = 4'd0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_code = 2'd0;
   logic       act_ok, rd_ok, wr_ok, pre_ok, bank_open, rd_data_due, illegal_cmd;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ddr_bank_guard u_ddr_bank_guard (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_data(cfg_data), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .act_ok(act_ok), .rd_ok(rd_ok), .wr_ok(wr_ok),
      .pre_ok(pre_ok), .bank_open(bank_open), .rd_data_due(rd_data_due),
      .illegal_cmd(illegal_cmd)
   );

   task automatic check(input string req, input string what,
                        input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // command is sampled at the next rising edge; returns one cycle later
   task automatic issue(input logic [1:0] c);
      cmd_valid = 1'b1;
      cmd_code  = c;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_code  = 2'd0;
   endtask

   task automatic cfg_write(input logic en, input logic [1:0] sel, input logic [3:0] d);
      cfg_en = en; cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
      @(negedge clk);
      cfg_en = 1'b0; cfg_we = 1'b0;
   endtask

   task automatic t_reset;
      check("R9", "act_ok after reset", act_ok, 1'b1);
      check("R9", "rd_ok after reset", rd_ok, 1'b0);
      check("R9", "wr_ok after reset", wr_ok, 1'b0);
      check("R9", "pre_ok after reset", pre_ok, 1'b0);
      check("R9", "bank_open after reset", bank_open, 1'b0);
      check("R5", "rd_data_due after reset", rd_data_due, 1'b0);
      check("R6", "illegal_cmd after reset", illegal_cmd, 1'b0);
   endtask

   task automatic t_act_to_rw;
      issue(C_ACT);                                   // T+1
      check("R9", "bank_open after ACT", bank_open, 1'b1);
      check("R9", "act_ok while open", act_ok, 1'b0);
      check("R2", "rd_ok at T+1", rd_ok, 1'b0);
      check("R2", "wr_ok at T+1", wr_ok, 1'b0);
      idle(1);                                        // T+2
      check("R2", "wr_ok at T+2", wr_ok, 1'b0);
      idle(1);                                        // T+3
      check("R2", "rd_ok at T+3", rd_ok, 1'b1);
      check("R2", "wr_ok at T+3", wr_ok, 1'b1);
   endtask

   task automatic t_read_latency;
      issue(C_RD);                                    // R+1
      check("R5", "due at R+1 (CL 2)", rd_data_due, 1'b0);
      for (int i = 0; i < 4; i++) begin
         idle(1);                                     // R+2..R+5
         check("R5", "due in burst (CL 2)", rd_data_due, 1'b1);
      end
      idle(1);                                        // R+6
      check("R5", "due after burst (CL 2)", rd_data_due, 1'b0);
   endtask

   task automatic t_write_windows;
      issue(C_WR);                                    // W+1
      check("R4", "rd_ok in write burst", rd_ok, 1'b0);
      check("R3", "pre_ok in write burst", pre_ok, 1'b0);
      idle(4);                                        // W+5
      check("R4", "rd_ok at W+5", rd_ok, 1'b0);
      check("R3", "pre_ok at W+5", pre_ok, 1'b0);
      idle(1);                                        // W+6
      check("R4", "rd_ok at W+6", rd_ok, 1'b1);
      check("R3", "pre_ok at W+6", pre_ok, 1'b0);
      idle(1);                                        // W+7
      check("R3", "pre_ok at W+7", pre_ok, 1'b1);
   endtask

   task automatic t_write_restart;
      issue(C_WR);                                    // W+1
      idle(1);                                        // W+2
      issue(C_WR);                                    // W+3
      idle(4);                                        // W+7
      check("R7", "pre_ok at first write's end", pre_ok, 1'b0);
      idle(1);                                        // W+8
      check("R7", "pre_ok at W+8", pre_ok, 1'b0);
      idle(1);                                        // W+9
      check("R7", "pre_ok after restarted window", pre_ok, 1'b1);
   endtask

   task automatic t_closed_bank;
      logic saw_due;
      issue(C_PRE);                                   // P+1
      check("R9", "bank_open after PRE", bank_open, 1'b0);
      check("R9", "act_ok after PRE", act_ok, 1'b1);
      check("R9", "rd_ok while closed", rd_ok, 1'b0);
      check("R6", "illegal_cmd idle", illegal_cmd, 1'b0);
      issue(C_RD);
      check("R6", "illegal_cmd after closed READ", illegal_cmd, 1'b1);
      saw_due = 1'b0;
      for (int i = 0; i < 6; i++) begin
         idle(1);
         saw_due |= rd_data_due;
      end
      check("R6", "illegal_cmd is one cycle", illegal_cmd, 1'b0);
      check("R6", "no read data for closed READ", saw_due, 1'b0);
      issue(C_WR);                                    // X+1
      check("R6", "illegal_cmd after closed WRITE", illegal_cmd, 1'b1);
      issue(C_ACT);                                   // X+2
      idle(2);                                        // X+4 = ACT+3
      check("R6", "no burst from closed WRITE (rd_ok)", rd_ok, 1'b1);
      issue(C_PRE);
   endtask

   task automatic t_config;
      cfg_write(1'b1, 2'd0, 4'd0);                    // activate-to-rw = 0
      issue(C_ACT);
      check("R2", "rd_ok at T+1 with value 0", rd_ok, 1'b1);
      check("R2", "wr_ok at T+1 with value 0", wr_ok, 1'b1);
      cfg_write(1'b1, 2'd0, 4'd5);                    // bank open: ignored
      issue(C_PRE);
      cfg_write(1'b0, 2'd0, 4'd4);                    // enable low: ignored
      issue(C_ACT);
      check("R8", "ignored writes left value 0", rd_ok, 1'b1);
      issue(C_PRE);
      cfg_write(1'b1, 2'd3, 4'd3);                    // CAS latency 3
      cfg_write(1'b1, 2'd0, 4'd3);
      issue(C_ACT);
      idle(2);
      issue(C_RD);                                    // R+1
      idle(1);                                        // R+2
      check("R1", "due at R+2 (CL 3)", rd_data_due, 1'b0);
      idle(1);                                        // R+3
      check("R1", "due at R+3 (CL 3)", rd_data_due, 1'b1);
      idle(3);                                        // R+6
      check("R5", "due at R+6 (CL 3)", rd_data_due, 1'b1);
      idle(1);                                        // R+7
      check("R5", "due at R+7 (CL 3)", rd_data_due, 1'b0);
      issue(C_PRE);
      cfg_write(1'b1, 2'd3, 4'd0);                    // CAS latency 0 -> 1
      issue(C_ACT);
      idle(2);
      issue(C_RD);                                    // R+1
      check("R5", "due at R+1 (CL 0)", rd_data_due, 1'b1);
      idle(3);                                        // R+4
      check("R5", "due at R+4 (CL 0)", rd_data_due, 1'b1);
      idle(1);                                        // R+5
      check("R5", "due at R+5 (CL 0)", rd_data_due, 1'b0);
      issue(C_PRE);
      cfg_write(1'b1, 2'd1, 4'd5);                    // write recovery 5
      issue(C_ACT);
      idle(2);
      issue(C_WR);                                    // W+1
      idle(6);                                        // W+7
      check("R1", "pre_ok at W+7 (recovery 5)", pre_ok, 1'b0);
      idle(1);                                        // W+8
      check("R1", "pre_ok at W+8 (recovery 5)", pre_ok, 1'b0);
      idle(1);                                        // W+9
      check("R1", "pre_ok at W+9 (recovery 5)", pre_ok, 1'b1);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected<=20000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_act_to_rw();
      t_read_latency();
      t_write_windows();
      t_write_restart();
      t_closed_bank();
      t_config();
      idle(2);
      finish_run();
   end

endmodule